// File: doc/BRIEF.md
# Prefetch-Tolerant Register Bank with Transmit Frame Buffer

This block is a small register file that sits behind a bridge's internal word bus. The master on the far side of that bridge fetches ahead of what software asked for, caches what it fetched, and merges nearby writes into longer bursts. The register file is built so that this master still sees correct behaviour. Each 32-bit register occupies the first word of its own 32-byte slot, and the rest of each slot is inert padding. The status word is decoded in two neighbouring slots, so software can poll it by alternating between the two addresses and miss the master's cache on every poll. No read ever changes state.

A linear transmit buffer takes full 32-bit words in strictly increasing order through an internal write pointer. Software then writes the frame length in bytes to a length register and sets the start bit of a commit register. The block streams exactly that many bytes, lowest byte of each word first, to a downstream valid/ready byte port. Any trailing words that a merged burst appended as padding never reach the stream. A commit that is empty or larger than the buffer is refused and raises a sticky error. Only a write to the control register clears that error.

Map (byte addresses): control 0x000, length 0x020, commit 0x040, status 0x060 and 0x080 (aliases), buffer from 0x100 for 4·BUF_WORDS bytes.

Top module: `pfrb_top`

## Requirements
- R1: After reset, the status reads as zero (busy bit 0 = 0, error bit 1 = 0, write pointer field bits [20:16] = 0), the length register reads zero, and tx_valid is low.
- R2: Only word 0 of a mapped slot is a register. A write to any other word of a slot, or to an unmapped slot, changes nothing, and a read of such an address returns zero.
- R3: Reads have no side effects. No number of reads of any address changes the length, the pointer, the error flag or the stream. Control and commit read as zero.
- R4: Status is decoded at 0x060 and at 0x080, and both addresses return the same live value.
- R5: Each full-word buffer write stores its data at the write pointer and advances the pointer by one. Once BUF_WORDS words are held, further buffer writes are dropped and the pointer stays at BUF_WORDS.
- R6: A frame delivers exactly the number of bytes held in the length register. Byte k is bits [8·(k mod 4)+7 : 8·(k mod 4)] of buffer word k/4. tx_last is high only on the final byte.
- R7: Writing 1 to commit bit 0 starts the frame. Busy (status bit 0) and tx_valid stay high until the final byte is accepted, and then drop on the next cycle. While tx_ready is low, tx_data holds steady.
- R8: The write pointer returns to zero on a commit with bit 0 set, or on a control write with bit 0 set.
- R9: A commit with length 0 or with length above 4·BUF_WORDS sends nothing and sets the error bit (status bit 1). Reads leave the bit set, and only a control write with bit 1 set clears it.
- R10: A write whose byte enables are not all ones is dropped, in every slot and in the buffer.
- R11: While busy, buffer writes and commit writes are ignored, and the frame in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench writes more words than the frame length, so trailing padding words are present. A design that sent words instead of honouring the byte length would emit extra bytes or place tx_last wrongly. It writes to padding words, to unmapped slots, and with partial byte enables. A loose decoder would then corrupt the length register or move the pointer. It reads the status repeatedly at both aliases while the error flag is set and while a frame is stalled by backpressure, to catch any read that clears state or an alias that returns a stale copy. It also commits lengths of zero, one past capacity and exactly capacity, and fills the buffer past its end, so that off-by-one limits would either send a bad frame or wrap the pointer.

// File: rtl/pfrb_pkg.sv
// Shared constants for the prefetch-tolerant register bank.
// Assumes 32-byte register slots and 32-bit data words.
package pfrb_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LEN,
        SEL_COMMIT,
        SEL_STAT,
        SEL_BUF
    } sel_e;

    localparam int SLOT_LSB        = 5;
    localparam int SLOT_CTRL       = 0;
    localparam int SLOT_LEN        = 1;
    localparam int SLOT_COMMIT     = 2;
    localparam int SLOT_STAT_A     = 3;
    localparam int SLOT_STAT_B     = 4;
    localparam int CTRL_PTR_CLR    = 0;
    localparam int CTRL_ERR_CLR    = 1;
    localparam int COMMIT_GO       = 0;
    localparam int STAT_BUSY       = 0;
    localparam int STAT_ERR        = 1;
    localparam int STAT_PTR_LSB    = 16;
endpackage

// File: rtl/pfrb_decode.sv
// Address decoder: maps a byte address to a register or buffer select.
// Assumes the buffer region does not overlap the register slots.
// Only word 0 of a slot selects a register; other words map to SEL_NONE.
module pfrb_decode
    import pfrb_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int BUF_BASE  = 256,
    parameter int BUF_WORDS = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam int BUF_END = BUF_BASE + 4 * BUF_WORDS;

    logic [31:0]              addr32;
    logic [ADDR_W-SLOT_LSB-1:0] slot;
    logic [SLOT_LSB-1:0]      in_slot;

    assign addr32  = 32'(addr);
    assign slot    = addr[ADDR_W-1:SLOT_LSB];
    assign in_slot = addr[SLOT_LSB-1:0];

    // Select the target of the current address
    always_comb begin
        sel = SEL_NONE;
        if (addr32 >= 32'(BUF_BASE) && addr32 < 32'(BUF_END)) begin
            sel = SEL_BUF;
        end else if (in_slot == '0) begin
            case (int'(slot))
                SLOT_CTRL:   sel = SEL_CTRL;
                SLOT_LEN:    sel = SEL_LEN;
                SLOT_COMMIT: sel = SEL_COMMIT;
                SLOT_STAT_A: sel = SEL_STAT;
                SLOT_STAT_B: sel = SEL_STAT;
                default:     sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pfrb_buffer.sv
// Linear frame buffer with an internal write pointer.
// Each accepted write lands at the pointer, which then advances.
// Writes past capacity are dropped. Clearing the pointer takes priority.
module pfrb_buffer #(
    parameter int BUF_WORDS = 16,
    parameter int IDX_W     = 4,
    parameter int PTR_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             ptr_clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [PTR_W-1:0] wr_ptr
);
    logic [31:0] mem [BUF_WORDS];
    logic        room;

    assign room    = wr_ptr < PTR_W'(BUF_WORDS);
    assign rd_word = mem[rd_idx];

    // Pointer maintenance: clear, or advance on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clr) begin
            wr_ptr <= '0;
        end else if (wr_en && room) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end
    end

    // Word storage, cleared at reset so unwritten words read as zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_WORDS; i++) mem[i] <= '0;
        end else if (wr_en && room && !ptr_clr) begin
            mem[wr_ptr[IDX_W-1:0]] <= wr_data;
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= PTR_W'(BUF_WORDS)); // R5
    AST_PTR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> wr_ptr == '0); // R8
endmodule

// File: rtl/pfrb_tx.sv
// Frame streamer: on start, checks the length, then sends that many bytes
// from the buffer, lowest byte of each word first, over valid/ready.
// Owns the sticky error flag. Assumes the buffer is not written while busy.
module pfrb_tx #(
    parameter int LEN_W     = 16,
    parameter int BUF_BYTES = 64,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [LEN_W-1:0] len,
    input  logic             err_clr,
    output logic             busy,
    output logic             err,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [31:0]      rd_word,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic             bad_len;
    logic             at_end;

    assign bad_len  = (len == '0) || (len > LEN_W'(BUF_BYTES));
    assign at_end   = cnt == len_q - LEN_W'(1);
    assign rd_idx   = cnt[IDX_W+1:2];
    assign tx_data  = rd_word[8*cnt[1:0] +: 8];
    assign tx_valid = busy;
    assign tx_last  = busy && at_end;

    // Frame sequencing: accept or refuse start, then count accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            len_q <= '0;
        end else if (start_req && !busy) begin
            cnt   <= '0;
            len_q <= len;
            busy  <= !bad_len;
        end else if (busy && tx_ready) begin
            if (at_end) busy <= 1'b0;
            else        cnt  <= cnt + LEN_W'(1);
        end
    end

    // Sticky error: set by a refused start, cleared only by request
    always_ff @(posedge clk) begin
        if (!rst_n || err_clr) begin
            err <= 1'b0;
        end else if (start_req && !busy && bad_len) begin
            err <= 1'b1;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R7
endmodule

// File: rtl/pfrb_top.sv
// Register bank top: decodes word-bus accesses, holds the length register,
// drives the buffer and the streamer, and returns registered read data.
// Assumes one access per bus_req cycle; read data follows one cycle later.
module pfrb_top
    import pfrb_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int BUF_BASE  = 256,
    parameter int BUF_WORDS = 16,
    parameter int LEN_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int BUF_BYTES = 4 * BUF_WORDS;
    localparam int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam int PTR_W     = $clog2(BUF_WORDS + 1);

    sel_e              sel;
    logic              wr_ok;
    logic              commit_go;
    logic              ptr_clr;
    logic              err_clr;
    logic              buf_wr;
    logic              busy;
    logic              err;
    logic [LEN_W-1:0]  len_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  rd_idx;
    logic [31:0]       rd_word;
    logic [31:0]       stat_word;
    logic [31:0]       rd_mux;

    pfrb_decode #(
        .ADDR_W    (ADDR_W),
        .BUF_BASE  (BUF_BASE),
        .BUF_WORDS (BUF_WORDS)
    ) i_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_ok     = bus_req && bus_we && (&bus_be);
    assign commit_go = wr_ok && (sel == SEL_COMMIT) && bus_wdata[COMMIT_GO] && !busy;
    assign ptr_clr   = commit_go || (wr_ok && (sel == SEL_CTRL) && bus_wdata[CTRL_PTR_CLR]);
    assign err_clr   = wr_ok && (sel == SEL_CTRL) && bus_wdata[CTRL_ERR_CLR];
    assign buf_wr    = wr_ok && (sel == SEL_BUF) && !busy;

    pfrb_buffer #(
        .BUF_WORDS (BUF_WORDS),
        .IDX_W     (IDX_W),
        .PTR_W     (PTR_W)
    ) i_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_data (bus_wdata),
        .ptr_clr (ptr_clr),
        .rd_idx  (rd_idx),
        .rd_word (rd_word),
        .wr_ptr  (wr_ptr)
    );

    pfrb_tx #(
        .LEN_W     (LEN_W),
        .BUF_BYTES (BUF_BYTES),
        .IDX_W     (IDX_W)
    ) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (commit_go),
        .len       (len_q),
        .err_clr   (err_clr),
        .busy      (busy),
        .err       (err),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    // Length register: full-word writes to its slot only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_ok && sel == SEL_LEN) begin
            len_q <= bus_wdata[LEN_W-1:0];
        end
    end

    // Status word assembled from live state
    always_comb begin
        stat_word = '0;
        stat_word[STAT_BUSY] = busy;
        stat_word[STAT_ERR]  = err;
        stat_word[STAT_PTR_LSB +: PTR_W] = wr_ptr;
    end

    // Read mux: padding, control, commit and buffer read as zero
    always_comb begin
        case (sel)
            SEL_LEN:  rd_mux = 32'(len_q);
            SEL_STAT: rd_mux = stat_word;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read return, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            bus_rdata  <= (bus_req && !bus_we) ? rd_mux : '0;
        end
    end

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> ($stable(len_q) && $stable(wr_ptr))); // R3
    AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_go && (len_q == '0 || len_q > LEN_W'(BUF_BYTES))) |=> (err && !tx_valid)); // R9
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_req && bus_we && sel == SEL_BUF) |=> $stable(wr_ptr)); // R11
endmodule

// File: tb/test_pfrb_top.sv
// Directed bench for pfrb_top: one task per scenario, each checking itself.
module test_pfrb_top;
    localparam int AW = 9;
    localparam logic [AW-1:0] A_CTRL = 9'h000, A_LEN = 9'h020, A_COMMIT = 9'h040,
                              A_STA = 9'h060, A_STB = 9'h080, A_BUF = 9'h100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_rdata;
    logic bus_rvalid, tx_valid, tx_last;
    logic [7:0] tx_data;
    logic tx_ready = 1'b0;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] words [18];
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    pfrb_top i_pfrb_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_be = 4'hF;
    endtask

    task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] stat(input int ptr, input bit err, input bit busy);
        return (32'(ptr) << 16) | (32'(err) << 1) | 32'(busy);
    endfunction

    // Receive n bytes from words[], optionally stalling; checks data, last, end
    task automatic recv(input int n, input bit stall, input string tag);
        int got = 0, cyc = 0;
        while (got < n && cyc < 400) begin
            @(negedge clk);
            tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
            cyc++;
            if (tx_valid && tx_ready) begin
                chk({tag, " byte"}, 32'(tx_data), 32'(words[got/4][8*(got%4) +: 8]));
                chk({tag, " last"}, 32'(tx_last), 32'(got == n - 1));
                got++;
            end
        end
        chk({tag, " count"}, got, n);
        @(negedge clk);
        tx_ready = 0;
        chk("R7 valid drops after final byte", 32'(tx_valid), 0);
    endtask

    task automatic t_reset();
        rdw(A_STA, rd); chk("R1 status at reset", rd, 0);
        rdw(A_LEN, rd); chk("R1 length at reset", rd, 0);
        chk("R1 tx_valid at reset", 32'(tx_valid), 0);
    endtask

    task automatic t_padding();
        wr(A_LEN, 5);
        wr(A_LEN + 4, 99);
        wr(9'h0A0, 77);
        rdw(A_LEN, rd);  chk("R2 padding write ignored", rd, 5);
        rdw(A_LEN + 4, rd); chk("R2 padding reads zero", rd, 0);
        rdw(9'h0A0, rd); chk("R2 unmapped slot reads zero", rd, 0);
        wr(A_LEN, 7, 4'b0011);
        rdw(A_LEN, rd);  chk("R10 partial length write dropped", rd, 5);
        wr(A_BUF, 32'h1234, 4'b1110);
        wr(A_COMMIT, 1, 4'b0001);
        rdw(A_STA, rd);  chk("R10 partial buffer/commit write dropped", rd, stat(0, 0, 0));
    endtask

    task automatic t_reads();
        wr(A_CTRL, 1);
        wr(A_BUF, 32'hAAAA_5555);
        for (int i = 0; i < 6; i++) rdw((i % 2) ? A_STA : A_STB, rd);
        rdw(A_CTRL, rd);   chk("R3 control reads zero", rd, 0);
        rdw(A_COMMIT, rd); chk("R3 commit reads zero", rd, 0);
        rdw(A_BUF, rd);
        rdw(A_STA, rd);    chk("R3 reads leave pointer", rd, stat(1, 0, 0));
        chk("R3 reads start no frame", 32'(tx_valid), 0);
    endtask

    task automatic t_frame_basic();
        logic [31:0] a, b;
        wr(A_CTRL, 1);
        for (int i = 0; i < 6; i++) begin
            words[i] = 32'hA1B2_C3D4 + 32'(i) * 32'h0101_0101;
            wr(A_BUF + AW'(4 * i), words[i]);
        end
        wr(A_LEN, 13);
        rdw(A_STA, rd); chk("R5 pointer counts words", rd, stat(6, 0, 0));
        wr(A_COMMIT, 1);
        chk("R7 commit starts frame", 32'(tx_valid), 1);
        rdw(A_STA, a); rdw(A_STB, b);
        chk("R4 alias A during frame", a, stat(0, 0, 1));
        chk("R4 alias B matches A", b, a);
        chk("R8 commit cleared pointer", a >> 16, 0);
        recv(13, 0, "R6 frame of 13 bytes");
        rdw(A_STA, rd); chk("R7 busy clear after frame", rd, stat(0, 0, 0));
    endtask

    task automatic t_frame_stall();
        wr(A_CTRL, 1);
        words[0] = 32'h0403_0201; words[1] = 32'h0807_0605;
        wr(A_BUF, words[0]); wr(A_BUF + 4, words[1]);
        wr(A_LEN, 8);
        wr(A_COMMIT, 1);
        wr(A_BUF, 32'hDEAD_BEEF);
        wr(A_COMMIT, 1);
        repeat (3) @(negedge clk);
        chk("R7 holds valid under backpressure", 32'(tx_valid), 1);
        rdw(A_STA, rd); chk("R11 busy drops buffer write", rd, stat(0, 0, 1));
        recv(8, 1, "R11 R6 stalled frame intact");
    endtask

    task automatic t_overflow();
        wr(A_CTRL, 1);
        for (int i = 0; i < 18; i++) begin
            words[i] = 32'h1000_0000 + 32'(i);
            wr(A_BUF + AW'(4 * (i % 16)), words[i]);
        end
        rdw(A_STA, rd); chk("R5 pointer stops at capacity", rd, stat(16, 0, 0));
        wr(A_LEN, 64);
        wr(A_COMMIT, 1);
        recv(64, 0, "R5 R6 full-capacity frame");
    endtask

    task automatic t_reject();
        logic [31:0] a, b;
        wr(A_LEN, 0);
        wr(A_COMMIT, 1);
        chk("R9 zero length sends nothing", 32'(tx_valid), 0);
        rdw(A_STA, a); rdw(A_STB, b);
        chk("R9 error after zero length", a, stat(0, 1, 0));
        chk("R4 alias B equals A with error", b, a);
        rdw(A_STA, rd); chk("R9 error sticky across reads", rd, stat(0, 1, 0));
        wr(A_CTRL, 2);
        rdw(A_STA, rd); chk("R9 control clears error", rd, stat(0, 0, 0));
        wr(A_LEN, 65);
        wr(A_COMMIT, 1);
        chk("R9 oversize sends nothing", 32'(tx_valid), 0);
        rdw(A_STB, rd); chk("R9 error after oversize", rd, stat(0, 1, 0));
        wr(A_CTRL, 2);
    endtask

    task automatic t_ptr_clr();
        wr(A_BUF, 1); wr(A_BUF + 4, 2);
        rdw(A_STA, rd); chk("R8 pointer before clear", rd, stat(2, 0, 0));
        wr(A_CTRL, 1);
        rdw(A_STA, rd); chk("R8 control clears pointer", rd, stat(0, 0, 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_padding();
        t_reads();
        t_frame_basic();
        t_frame_stall();
        t_overflow();
        t_reject();
        t_ptr_clr();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule